// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns internal read and write requests into cycles on a 16-line shared address/data bus. An address-latch strobe marks the address phase, and active-low read and write strobes mark the data phase. The bus has two widths. With byte units, the address phase puts the upper 16 bits of a 24-bit unit address on the lines. The data phase then carries the low address byte on the upper lines and the data byte on the lower lines. With halfword units, the address phase carries the full 16-bit unit address and the data phase carries only the 16-bit data.

A request can move one external unit or pack several units into one 32-bit internal word. A packed word takes four consecutive byte addresses or two consecutive halfword addresses, least significant unit first. Each data phase holds its strobe low for a programmable number of clocks, never fewer than two, followed by one recovery clock. In byte mode the block remembers the last latched upper address. It skips the address phase while accesses stay inside one 256-unit page, so sequential bytes move at one unit per three clocks.

Requests use a valid/ready handshake. Ready is high only while the bus is idle. A request is taken on a clock where valid and ready are both high, and the requester must hold its fields stable until then. Completion is a single-clock done pulse, and the read word is shown on the result output in that same cycle. The done pulse has no back-pressure: the result must be consumed in that cycle. The mode and wait inputs are plain configuration pins. The mode is sampled when a request is taken, and the wait count is sampled at the start of each data phase.

Top module: `adbus_master`

## Requirements
- R1: After reset, rd_n and wr_n are 1, ale is 0, req_ready is 1 and rsp_done is 0.
- R2: In byte mode (cfg_wide=0), during an address phase ale is 1 and ad_out carries unit address bits 23:8.
- R3: In byte mode, during the data phase ad_out[15:8] carries address bits 7:0 and ad_out[7:0] the data byte. ad_oe is 2'b11 for a write and 2'b10 for a read, so the low byte is released for a read.
- R4: In halfword mode (cfg_wide=1), every unit is preceded by an address phase carrying address bits 15:0. The data phase carries data on all 16 lines with ad_oe=2'b11 for a write and 2'b00 for a read.
- R5: The read or write strobe stays low for max(cfg_wait, 2) consecutive clocks. A read samples ad_in on the last low clock.
- R6: With req_pack=1, byte mode moves four units at addresses A..A+3 and halfword mode moves two units at A and A+1. Unit k occupies word bits starting at k times the unit width.
- R7: In byte mode an address phase is issued only when the upper address differs from the one last latched, or when the last latch was made in halfword mode. Within a page, consecutive unit strobes fall three clocks apart when the wait is 2.
- R8: req_ready is high only when idle, and rsp_done is a one-clock pulse after the last unit. A new request may be taken in the same clock that rsp_done is high.
- R9: rd_n and wr_n are never low together, and ale is never high while either strobe is low.
- R10: With req_pack=0 exactly one unit moves. A write takes the low unit of req_wdata, and a read returns the unit zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 0: byte units, 24-bit address; 1: halfword units, 16-bit address |
| cfg_wait | input | 5 | Strobe-low length in clocks (values below 2 act as 2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pack | input | 1 | 1 = pack units into a 32-bit word, 0 = single unit |
| req_addr | input | 24 | External unit address of the first unit |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Assembled read word, valid with rsp_done |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 16 | Multiplexed address/data lines, driven value |
| ad_oe | output | 2 | Output enable per byte lane of ad_out |
| ad_in | input | 16 | Multiplexed lines, sampled value |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same clock. A byte write is followed immediately by a byte read in the same page. The bench checks that done and ready are both high on that clock, that the read proceeds without a fresh address phase, and that it returns the correct zero-extended byte. A second overlap is a page crossing in the middle of a packed word. The bench places a packed read at offset 0xFE, so a new address phase must appear between the second and third bytes and the assembled word must still come out in order.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALE    = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } bus_state_e;
endpackage

// File: rtl/adbus_waitctr.sv
module adbus_waitctr #(
  parameter int WAIT_W   = 5,
  parameter int MIN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] cfg,
  output logic              last
);
  localparam logic [WAIT_W-1:0] MIN_V = WAIT_W'(MIN_WAIT);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] eff;

  always_comb eff = (cfg < MIN_V) ? MIN_V : cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= eff - WAIT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/adbus_packer.sv
module adbus_packer #(
  parameter int WORD_W = 32,
  parameter int AD_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [WORD_W-1:0]               load_data,
  input  logic                            wide,
  input  logic [$clog2(WORD_W/8)-1:0]     idx,
  input  logic                            capture,
  input  logic [AD_W-1:0]                 cap_data,
  output logic [AD_W-1:0]                 unit_out,
  output logic [WORD_W-1:0]               word_out
);
  localparam int NB    = WORD_W / 8;
  localparam int IDX_W = $clog2(NB);

  logic [WORD_W-1:0] word_q;

  always_comb begin
    if (wide) unit_out = word_q[16*idx +: 16];
    else      unit_out = {{(AD_W-8){1'b0}}, word_q[8*idx +: 8]};
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    always_comb begin
      hit = wide ? (idx == IDX_W'(b/2)) : (idx == IDX_W'(b));
      src = wide ? cap_data[(b%2)*8 +: 8] : cap_data[7:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              word_q[b*8 +: 8] <= '0;
      else if (load)           word_q[b*8 +: 8] <= load_data[b*8 +: 8];
      else if (capture && hit) word_q[b*8 +: 8] <= src;
    end
  end

  assign word_out = word_q;
endmodule

// File: rtl/adbus_master.sv
module adbus_master
  import adbus_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int AD_W     = 16,
  parameter int WORD_W   = 32,
  parameter int WAIT_W   = 5,
  parameter int MIN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_pack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [AD_W-1:0]   ad_out,
  output logic [1:0]        ad_oe,
  input  logic [AD_W-1:0]   ad_in
);
  localparam int LOW_W  = AD_W / 2;
  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int NB     = WORD_W / 8;
  localparam int IDX_W  = $clog2(NB);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NB - 1);
  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(NB/2 - 1);

  bus_state_e        state_q;
  logic              wr_q, wide_q, pack_q, done_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic [PAGE_W-1:0] page_q;
  logic              page_ok_q;
  logic              accept, ale_acc, ale_nxt, at_last, ctr_load, ctr_last, capture;
  logic [AD_W-1:0]   unit_w;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign nxt_addr  = addr_q + ADDR_W'(1);
  assign last_idx  = !pack_q ? '0 : (wide_q ? LAST_HALF : LAST_BYTE);
  assign at_last   = (idx_q == last_idx);

  always_comb begin
    ale_acc = cfg_wide || !page_ok_q || (page_q != req_addr[ADDR_W-1:LOW_W]);
    ale_nxt = wide_q || !page_ok_q || (page_q != nxt_addr[ADDR_W-1:LOW_W]);
  end

  assign ctr_load = (accept && !ale_acc) || (state_q == ST_ALE) ||
                    (state_q == ST_HOLD && !at_last && !ale_nxt);
  assign capture  = (state_q == ST_STROBE) && !wr_q && ctr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      pack_q    <= 1'b0;
      addr_q    <= '0;
      idx_q     <= '0;
      page_q    <= '0;
      page_ok_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          wide_q  <= cfg_wide;
          pack_q  <= req_pack;
          addr_q  <= req_addr;
          idx_q   <= '0;
          state_q <= ale_acc ? ST_ALE : ST_STROBE;
        end
        ST_ALE: begin
          page_q    <= addr_q[ADDR_W-1:LOW_W];
          page_ok_q <= !wide_q;
          state_q   <= ST_STROBE;
        end
        ST_STROBE: if (ctr_last) state_q <= ST_HOLD;
        ST_HOLD: begin
          if (at_last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            addr_q  <= nxt_addr;
            state_q <= ale_nxt ? ST_ALE : ST_STROBE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adbus_waitctr #(.WAIT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ctr_load),
    .cfg  (cfg_wait),
    .last (ctr_last)
  );

  adbus_packer #(.WORD_W(WORD_W), .AD_W(AD_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(req_write ? req_wdata : '0),
    .wide     (wide_q),
    .idx      (idx_q),
    .capture  (capture),
    .cap_data (ad_in),
    .unit_out (unit_w),
    .word_out (rsp_rdata)
  );

  assign rsp_done = done_q;
  assign ale      = (state_q == ST_ALE);
  assign rd_n     = !((state_q == ST_STROBE) && !wr_q);
  assign wr_n     = !((state_q == ST_STROBE) &&  wr_q);

  always_comb begin
    ad_out = '0;
    ad_oe  = 2'b00;
    unique case (state_q)
      ST_ALE: begin
        ad_out = wide_q ? addr_q[AD_W-1:0] : addr_q[ADDR_W-1:LOW_W];
        ad_oe  = 2'b11;
      end
      ST_STROBE, ST_HOLD: begin
        ad_out = wide_q ? unit_w : {addr_q[LOW_W-1:0], unit_w[LOW_W-1:0]};
        ad_oe  = wr_q ? 2'b11 : (wide_q ? 2'b00 : 2'b10);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adbus_master_chk.sv
module adbus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_done,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] ad_oe
);
  p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_ale_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  p_read_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);
  p_write_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |=> !wr_n);
  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe[0]);
  p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe == 2'b11));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ale));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind adbus_master adbus_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .ad_oe    (ad_oe)
);

// File: tb/adbus_master_test.sv
module adbus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [4:0]  cfg_wait = 5'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_pack = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        ale, rd_n, wr_n;
  logic [15:0] ad_out;
  logic [1:0]  ad_oe;
  logic [15:0] ad_in;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int viol = 0;

  always #2 clk = ~clk;

  adbus_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pack(req_pack), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] rd8(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [15:0] rd16(input logic [15:0] a);
    return a ^ 16'hA55A;
  endfunction

  // external device: address latch and read responder
  logic [15:0] lat = '0;
  assign ad_in = cfg_wide ? rd16(lat) : {8'h00, rd8({lat, ad_out[15:8]})};

  // bus monitor
  int          ale_cnt = 0;
  int          rec_n = 0;
  int          cur_len = 0;
  int          rec_len   [64];
  int          rec_start [64];
  logic [15:0] rec_ad    [64];
  logic [1:0]  rec_oe    [64];
  logic [15:0] rec_lat   [64];
  logic        rec_w     [64];

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!rd_n && !wr_n) viol++;
      if (ale && (!rd_n || !wr_n)) viol++;
      if (!rd_n || !wr_n) begin
        if (cur_len == 0 && rec_n < 64) rec_start[rec_n] = cyc;
        cur_len++;
        if (rec_n < 64) begin
          rec_ad[rec_n]  = ad_out;
          rec_oe[rec_n]  = ad_oe;
          rec_lat[rec_n] = lat;
          rec_w[rec_n]   = !wr_n;
          rec_len[rec_n] = cur_len;
        end
      end else if (cur_len > 0) begin
        rec_n++;
        cur_len = 0;
      end
      if (ale) begin
        lat = ad_out;
        ale_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic pk, input logic [23:0] a,
                       input logic [31:0] d);
    req_write = wr; req_pack = pk; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!rsp_done) @(negedge clk);
  endtask

  task automatic t_reset();
    check(rd_n === 1'b1 && wr_n === 1'b1, "R1", "strobes idle", {30'b0, rd_n, wr_n}, 32'h3);
    check(ale === 1'b0, "R1", "ale idle", {31'b0, ale}, 32'h0);
    check(req_ready === 1'b1 && rsp_done === 1'b0, "R1", "ready/done",
          {30'b0, req_ready, rsp_done}, 32'h2);
  endtask

  task automatic t_byte_write();
    int a0 = ale_cnt; int r0 = rec_n;
    cfg_wide = 1'b0; cfg_wait = 5'd2;
    @(negedge clk);
    issue(1'b1, 1'b0, 24'h123456, 32'hFFFF_FFAB);
    wait_done();
    check(ale_cnt - a0 == 1, "R7", "first access latches", ale_cnt - a0, 1);
    check(rec_n - r0 == 1, "R10", "single unit count", rec_n - r0, 1);
    check(rec_lat[r0] == 16'h1234, "R2", "address phase upper bits", rec_lat[r0], 16'h1234);
    check(rec_ad[r0] == 16'h56AB, "R3", "write data phase", rec_ad[r0], 16'h56AB);
    check(rec_oe[r0] == 2'b11, "R3", "write drives both lanes", rec_oe[r0], 2'b11);
    check(rec_len[r0] == 2, "R5", "strobe length wait=2", rec_len[r0], 2);
  endtask

  task automatic t_byte_read_pack();
    int a0 = ale_cnt; int r0 = rec_n;
    logic [31:0] exp;
    exp = {rd8(24'h12345B), rd8(24'h12345A), rd8(24'h123459), rd8(24'h123458)};
    @(negedge clk);
    issue(1'b0, 1'b1, 24'h123458, 32'h0);
    wait_done();
    check(rsp_rdata == exp, "R6", "packed byte read", rsp_rdata, exp);
    check(ale_cnt == a0, "R7", "no address phase in page", ale_cnt - a0, 0);
    check(rec_n - r0 == 4, "R6", "four units", rec_n - r0, 4);
    for (int k = 0; k < 4; k++) begin
      check(rec_ad[r0+k][15:8] == 8'h58 + 8'(k), "R3", "low address byte",
            rec_ad[r0+k][15:8], 8'h58 + 8'(k));
      check(rec_oe[r0+k] == 2'b10, "R3", "read releases low lane", rec_oe[r0+k], 2'b10);
    end
    for (int k = 1; k < 4; k++)
      check(rec_start[r0+k] - rec_start[r0+k-1] == 3, "R7", "unit spacing",
            rec_start[r0+k] - rec_start[r0+k-1], 3);
  endtask

  task automatic t_page_cross();
    int a0 = ale_cnt; int r0 = rec_n;
    logic [31:0] exp;
    exp = {rd8(24'h123501), rd8(24'h123500), rd8(24'h1234FF), rd8(24'h1234FE)};
    @(negedge clk);
    issue(1'b0, 1'b1, 24'h1234FE, 32'h0);
    wait_done();
    check(rsp_rdata == exp, "R6", "packed read over page edge", rsp_rdata, exp);
    check(ale_cnt - a0 == 1, "R7", "one address phase at crossing", ale_cnt - a0, 1);
    check(rec_lat[r0+1] == 16'h1234 && rec_lat[r0+2] == 16'h1235, "R2",
          "upper address after crossing", rec_lat[r0+2], 16'h1235);
  endtask

  task automatic t_waits();
    int r0;
    logic [4:0] w [3] = '{5'd7, 5'd0, 5'd31};
    int el [3] = '{7, 2, 31};
    for (int i = 0; i < 3; i++) begin
      r0 = rec_n;
      cfg_wait = w[i];
      @(negedge clk);
      issue(1'b1, 1'b0, 24'h123501, 32'h11);
      wait_done();
      check(rec_len[r0] == el[i], "R5", "strobe length", rec_len[r0], el[i]);
    end
    cfg_wait = 5'd2;
  endtask

  task automatic t_half_write();
    int a0 = ale_cnt; int r0 = rec_n;
    cfg_wide = 1'b1;
    @(negedge clk);
    issue(1'b1, 1'b1, 24'h000100, 32'hDEADBEEF);
    wait_done();
    check(ale_cnt - a0 == 2, "R4", "address phase per unit", ale_cnt - a0, 2);
    check(rec_lat[r0] == 16'h0100 && rec_ad[r0] == 16'hBEEF, "R6", "low half first",
          {rec_lat[r0], rec_ad[r0]}, 32'h0100BEEF);
    check(rec_lat[r0+1] == 16'h0101 && rec_ad[r0+1] == 16'hDEAD, "R6", "high half second",
          {rec_lat[r0+1], rec_ad[r0+1]}, 32'h0101DEAD);
    check(rec_oe[r0] == 2'b11 && rec_w[r0], "R4", "write drives", rec_oe[r0], 2'b11);
  endtask

  task automatic t_half_read();
    int r0 = rec_n;
    logic [31:0] exp;
    exp = {rd16(16'h0201), rd16(16'h0200)};
    @(negedge clk);
    issue(1'b0, 1'b1, 24'h000200, 32'h0);
    wait_done();
    check(rsp_rdata == exp, "R4", "packed halfword read", rsp_rdata, exp);
    check(rec_oe[r0] == 2'b00 && rec_oe[r0+1] == 2'b00, "R4", "read releases bus",
          {rec_oe[r0], rec_oe[r0+1]}, 0);
  endtask

  task automatic t_back_to_back();
    int a0; int a1;
    logic [31:0] exp;
    exp = {24'h0, rd8(24'h123457)};
    cfg_wide = 1'b0;
    a0 = ale_cnt;
    @(negedge clk);
    issue(1'b1, 1'b0, 24'h123456, 32'h77);
    wait_done();
    check(ale_cnt - a0 == 1, "R7", "mode change forces address phase", ale_cnt - a0, 1);
    check(req_ready === 1'b1, "R8", "ready with done", {31'b0, req_ready}, 1);
    a1 = ale_cnt;
    issue(1'b0, 1'b0, 24'h123457, 32'h0);
    wait_done();
    check(rsp_rdata == exp, "R10", "single read zero-extended", rsp_rdata, exp);
    check(ale_cnt == a1, "R8", "overlapped request reuses page", ale_cnt - a1, 0);
    @(negedge clk);
    check(rsp_done === 1'b0, "R8", "done is one clock", {31'b0, rsp_done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_write();
    t_byte_read_pack();
    t_page_cross();
    t_waits();
    t_half_write();
    t_half_read();
    t_back_to_back();
    check(viol == 0, "R9", "strobe exclusion", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual %0d expected <100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule